// File: doc/BRIEF.md
# Debug Register Block with Hart Halt Tracking

This block is the register file of a small on-chip debug unit. A debug transport reaches it through a 7-bit-addressed request port. Each request takes one cycle, and the block answers exactly one cycle later with read data and an error flag. The control register holds a module-enable bit, a hart-reset bit, a halt-request bit and a hart selector. Two windows of general words sit beside it: a window of data words and a window of program-buffer words. Two read-only status words report how large those windows are.

On the hart side, the block drives one halt-request line per hart. It also watches a fetch port into the debug-entry region. Every load from that region answers with a jump-to-self instruction. A load also marks the hart whose index equals the word slot as halted. When the control register is read, the hart status field is derived at that moment from the halted flags and from whether the selected hart exists.

The response path is a three-state machine with states IDLE, DATA and ERROR. It moves from any state to IDLE when no request arrives. It moves to DATA on a request that decodes cleanly and to ERROR on a request that does not.

Top module: `dm_dmi_top`

## Requirements
- R1: After reset, rsp_valid and fetch_rsp_valid are 0, every halt_req line is 0, and the control register reads with enable 0, hart-reset 0, selector 0, halt request 0, version field [3:2] = 1, auth-busy bit 4 = 0, authenticated bit 5 = 1 and auth-type field [7:6] = 0.
- R2: Addresses 0x04 up to 0x04+DATACOUNT-1 address data words by offset. A write stores the 32-bit word, a read returns it, and neither reports an error.
- R3: Addresses 0x20 up to 0x20+PROGSIZE-1 address program-buffer words by offset, with the same behaviour as R2.
- R4: A write to the control register at 0x10 always stores the enable bit (bit 0). When the written enable is 1, the same write also stores hart-reset (bit 1), halt request (bit 31) and the selector (bits [25:16]). When it is 0, those three fields are cleared and every halt_req line drops.
- R5: A control write with enable 1 sets the halt_req line of the written selector to the written halt request when the selector is below NUM_HARTS. Every other line keeps its value, and a selector at or above NUM_HARTS changes no line.
- R6: On a control read, the hart status field [9:8] is 2 when the stored selector is at or above NUM_HARTS, 1 when that hart's halted flag is set, and 0 otherwise. Bit 31 shows the selected hart's halt_req line, or the stored halt request when that hart does not exist.
- R7: A read of 0x16 returns DATACOUNT in bits [4:0]. A read of 0x17 returns PROGSIZE in bits [4:0]. All other bits are 0.
- R8: A write to 0x16 or 0x17, and any access to an address not named in R2 to R7, returns rsp_err = 1 with rdata 0 and leaves every register unchanged.
- R9: A fetch load answers one cycle later with fetch_rdata = 0x0000006F and fetch_err = 0. It sets the halted flag of hart fetch_word when fetch_word is below NUM_HARTS.
- R10: A fetch store answers one cycle later with fetch_err = 1 and fetch_rdata 0, and sets no halted flag.
- R11: rsp_valid is 1 exactly in the cycle after each request and 0 otherwise. A successful write returns rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | 32 | Response read data |
| halt_req | output | NUM_HARTS | Per-hart halt request lines |
| fetch_valid | input | 1 | Hart access into the debug-entry region |
| fetch_write | input | 1 | 1 = store, 0 = load |
| fetch_word | input | log2(ENTRY_SLOTS) | Word slot within the region |
| fetch_rsp_valid | output | 1 | Fetch response strobe |
| fetch_rdata | output | 32 | Fetch response instruction word |
| fetch_err | output | 1 | Fetch response error flag |

## Verification
Every result of the request port (rsp_valid, rsp_err and rsp_rdata) is due in the cycle after the request. Halt-request lines change at the same edge as the control write, so they are also due one cycle later. Fetch responses and halted flags likewise follow the fetch one cycle later, and they show up in a control read issued after that. The bench drives every input on a falling edge and holds it for one cycle. It reads all outputs on the next falling edge, half a period after the edge that registered them, and it never overlaps a request with the check of the previous one.

// File: rtl/dm_dmi_pkg.sv
package dm_dmi_pkg;
    localparam logic [6:0] ADDR_DATA_BASE = 7'h04;
    localparam logic [6:0] ADDR_CTRL      = 7'h10;
    localparam logic [6:0] ADDR_CMD_STAT  = 7'h16;
    localparam logic [6:0] ADDR_ACC_STAT  = 7'h17;
    localparam logic [6:0] ADDR_PBUF_BASE = 7'h20;

    localparam int SEL_W = 10;
    localparam logic [31:0] SELF_LOOP_INSN = 32'h0000_006F;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_ERROR = 2'd2
    } rsp_state_e;

    typedef enum logic [1:0] {
        HS_RUNNING = 2'd0,
        HS_HALTED  = 2'd1,
        HS_ABSENT  = 2'd2
    } hart_state_e;
endpackage

// File: rtl/dm_word_store.sv
module dm_word_store #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    logic [31:0] words_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[w] <= '0;
            end else if (we && idx == IDX_W'(w)) begin
                words_q[w] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < DEPTH; w++) begin
            if (idx == IDX_W'(w)) rdata = words_q[w];
        end
    end
endmodule

// File: rtl/dm_hart_ctrl.sv
module dm_hart_ctrl
    import dm_dmi_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int SLOT_W    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  logic                 w_enable,
    input  logic                 w_hart_rst,
    input  logic                 w_halt,
    input  logic [SEL_W-1:0]     w_sel,
    output logic [31:0]          ctrl_rdata,
    output logic [NUM_HARTS-1:0] halt_req,
    input  logic                 fetch_valid,
    input  logic                 fetch_write,
    input  logic [SLOT_W-1:0]    fetch_word,
    output logic                 fetch_rsp_valid,
    output logic [31:0]          fetch_rdata,
    output logic                 fetch_err
);
    logic                 enable_q, hart_rst_q, halt_q;
    logic [SEL_W-1:0]     sel_q;
    logic [NUM_HARTS-1:0] halted_q, line_q;
    logic                 sel_exists, sel_line, sel_halted;
    hart_state_e          hstate;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q   <= 1'b0;
            hart_rst_q <= 1'b0;
            halt_q     <= 1'b0;
            sel_q      <= '0;
        end else if (ctrl_we) begin
            enable_q   <= w_enable;
            hart_rst_q <= w_enable & w_hart_rst;
            halt_q     <= w_enable & w_halt;
            sel_q      <= w_enable ? w_sel : '0;
        end
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q[h] <= 1'b0;
            end else if (ctrl_we && !w_enable) begin
                line_q[h] <= 1'b0;
            end else if (ctrl_we && w_sel == SEL_W'(h)) begin
                line_q[h] <= w_halt;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                halted_q[h] <= 1'b0;
            end else if (fetch_valid && !fetch_write && fetch_word == SLOT_W'(h)) begin
                halted_q[h] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_rsp_valid <= 1'b0;
            fetch_err       <= 1'b0;
            fetch_rdata     <= '0;
        end else begin
            fetch_rsp_valid <= fetch_valid;
            fetch_err       <= fetch_valid & fetch_write;
            fetch_rdata     <= (fetch_valid && !fetch_write) ? SELF_LOOP_INSN : '0;
        end
    end

    always_comb begin
        sel_exists = 1'b0;
        sel_line   = 1'b0;
        sel_halted = 1'b0;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (sel_q == SEL_W'(h)) begin
                sel_exists = 1'b1;
                sel_line   = line_q[h];
                sel_halted = halted_q[h];
            end
        end
        if (!sel_exists)     hstate = HS_ABSENT;
        else if (sel_halted) hstate = HS_HALTED;
        else                 hstate = HS_RUNNING;

        ctrl_rdata        = '0;
        ctrl_rdata[0]     = enable_q;
        ctrl_rdata[1]     = hart_rst_q;
        ctrl_rdata[3:2]   = 2'd1;
        ctrl_rdata[4]     = 1'b0;
        ctrl_rdata[5]     = 1'b1;
        ctrl_rdata[7:6]   = 2'd0;
        ctrl_rdata[9:8]   = hstate;
        ctrl_rdata[25:16] = sel_q;
        ctrl_rdata[31]    = sel_exists ? sel_line : halt_q;
    end

    assign halt_req = line_q;

    // R4
    deact_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && !w_enable |=> halt_req == '0);
    // R9
    halted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((halted_q & $past(halted_q)) == $past(halted_q)));
    // R10
    store_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_write |=> fetch_err && fetch_rsp_valid);
endmodule

// File: rtl/dm_dmi_top.sv
module dm_dmi_top
    import dm_dmi_pkg::*;
#(
    parameter int NUM_HARTS   = 4,
    parameter int DATACOUNT   = 4,
    parameter int PROGSIZE    = 8,
    parameter int ENTRY_SLOTS = 1024,
    localparam int SLOT_W     = $clog2(ENTRY_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [6:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_rdata,
    output logic [NUM_HARTS-1:0] halt_req,
    input  logic                 fetch_valid,
    input  logic                 fetch_write,
    input  logic [SLOT_W-1:0]    fetch_word,
    output logic                 fetch_rsp_valid,
    output logic [31:0]          fetch_rdata,
    output logic                 fetch_err
);
    localparam int DIDX_W   = (DATACOUNT > 1) ? $clog2(DATACOUNT) : 1;
    localparam int PIDX_W   = (PROGSIZE > 1) ? $clog2(PROGSIZE) : 1;
    localparam int DATA_END = int'(ADDR_DATA_BASE) + DATACOUNT;
    localparam int PBUF_END = int'(ADDR_PBUF_BASE) + PROGSIZE;

    logic              in_data, in_pbuf, bad, data_we, pbuf_we, ctrl_we;
    logic [31:0]       rd_val, data_rd, pbuf_rd, ctrl_rd;
    logic [DIDX_W-1:0] data_idx;
    logic [PIDX_W-1:0] pbuf_idx;
    rsp_state_e        rsp_q, rsp_d;
    logic [31:0]       rdata_q;

    assign in_data  = int'(req_addr) >= int'(ADDR_DATA_BASE) && int'(req_addr) < DATA_END;
    assign in_pbuf  = int'(req_addr) >= int'(ADDR_PBUF_BASE) && int'(req_addr) < PBUF_END;
    assign data_idx = DIDX_W'(req_addr - ADDR_DATA_BASE);
    assign pbuf_idx = PIDX_W'(req_addr - ADDR_PBUF_BASE);

    dm_word_store #(.DEPTH(DATACOUNT)) i_data (
        .clk(clk), .rst_n(rst_n), .we(data_we), .idx(data_idx),
        .wdata(req_wdata), .rdata(data_rd));

    dm_word_store #(.DEPTH(PROGSIZE)) i_pbuf (
        .clk(clk), .rst_n(rst_n), .we(pbuf_we), .idx(pbuf_idx),
        .wdata(req_wdata), .rdata(pbuf_rd));

    dm_hart_ctrl #(.NUM_HARTS(NUM_HARTS), .SLOT_W(SLOT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
        .w_enable(req_wdata[0]), .w_hart_rst(req_wdata[1]), .w_halt(req_wdata[31]),
        .w_sel(req_wdata[25:16]), .ctrl_rdata(ctrl_rd), .halt_req(halt_req),
        .fetch_valid(fetch_valid), .fetch_write(fetch_write), .fetch_word(fetch_word),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rdata(fetch_rdata), .fetch_err(fetch_err));

    // Address decode: picks the read value and the single write enable.
    always_comb begin
        rd_val  = '0;
        bad     = 1'b0;
        data_we = 1'b0;
        pbuf_we = 1'b0;
        ctrl_we = 1'b0;
        if (in_data) begin
            data_we = req_valid & req_write;
            if (!req_write) rd_val = data_rd;
        end else if (in_pbuf) begin
            pbuf_we = req_valid & req_write;
            if (!req_write) rd_val = pbuf_rd;
        end else begin
            case (req_addr)
                ADDR_CTRL: begin
                    ctrl_we = req_valid & req_write;
                    if (!req_write) rd_val = ctrl_rd;
                end
                ADDR_CMD_STAT: begin
                    bad = req_write;
                    if (!req_write) rd_val = {27'd0, 5'(DATACOUNT)};
                end
                ADDR_ACC_STAT: begin
                    bad = req_write;
                    if (!req_write) rd_val = {27'd0, 5'(PROGSIZE)};
                end
                default: bad = 1'b1;
            endcase
        end
    end

    // Next-state logic of the response machine.
    always_comb begin
        unique case (1'b1)
            !req_valid:      rsp_d = RSP_IDLE;
            req_valid && bad:  rsp_d = RSP_ERROR;
            default:         rsp_d = RSP_DATA;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            rsp_q   <= rsp_d;
            rdata_q <= (req_valid && !bad) ? rd_val : '0;
        end
    end

    // Outputs of the response machine.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (rsp_q)
            RSP_IDLE:  ;
            RSP_DATA:  rsp_valid = 1'b1;
            RSP_ERROR: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:   ;
        endcase
    end
    assign rsp_rdata = rdata_q;

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R8
    cmd_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == ADDR_CMD_STAT |=> rsp_err && rsp_rdata == '0);
endmodule

// File: tb/test_dm_dmi_top.sv
module test_dm_dmi_top;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 4, DC = 4, PS = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [6:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [NH-1:0] halt_req;
    logic fetch_valid = 1'b0, fetch_write = 1'b0;
    logic [9:0] fetch_word = '0;
    logic fetch_rsp_valid, fetch_err;
    logic [31:0] fetch_rdata;

    int checks = 0, errors = 0;

    logic m_en, m_rst, m_hr;
    logic [9:0] m_sel;
    logic [NH-1:0] m_line, m_halted;
    logic [31:0] m_data [DC];
    logic [31:0] m_pbuf [PS];

    dm_dmi_top #(.NUM_HARTS(NH), .DATACOUNT(DC), .PROGSIZE(PS), .ENTRY_SLOTS(1024)) i_dm_dmi_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .halt_req(halt_req),
        .fetch_valid(fetch_valid), .fetch_write(fetch_write), .fetch_word(fetch_word),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rdata(fetch_rdata), .fetch_err(fetch_err));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] r = '0;
        logic ex = int'(m_sel) < NH;
        r[0] = m_en; r[1] = m_rst; r[3:2] = 2'd1; r[5] = 1'b1;
        r[9:8] = !ex ? 2'd2 : (m_halted[m_sel[1:0]] ? 2'd1 : 2'd0);
        r[25:16] = m_sel;
        r[31] = ex ? m_line[m_sel[1:0]] : m_hr;
        return r;
    endfunction

    task automatic dmi(input logic w, input logic [6:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output logic e, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata; e = rsp_err; v = rsp_valid;
    endtask

    task automatic fetch(input logic w, input logic [9:0] slot,
                         output logic [31:0] rd, output logic e, output logic v);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_write = w; fetch_word = slot;
        @(negedge clk);
        fetch_valid = 1'b0;
        rd = fetch_rdata; e = fetch_err; v = fetch_rsp_valid;
        if (!w && int'(slot) < NH) m_halted[slot[1:0]] = 1'b1;
    endtask

    task automatic ctrl_write(input logic [31:0] wd);
        logic [31:0] rd; logic e, v;
        dmi(1'b1, 7'h10, wd, rd, e, v);
        m_en = wd[0];
        if (wd[0]) begin
            m_hr = wd[31]; m_rst = wd[1]; m_sel = wd[25:16];
            if (int'(wd[25:16]) < NH) m_line[wd[17:16]] = wd[31];
        end else begin
            m_hr = 1'b0; m_rst = 1'b0; m_sel = '0; m_line = '0;
        end
        chk("R11 ctrl write resp", {29'd0, v, e, 1'b0} | rd, 32'h4);
        chk("R5 halt_req lines", 32'(halt_req), 32'(m_line));
    endtask

    task automatic ctrl_read(input string req);
        logic [31:0] rd; logic e, v;
        dmi(1'b0, 7'h10, '0, rd, e, v);
        chk(req, rd, exp_ctrl());
        chk("R11 ctrl read valid/err", {30'd0, v, e}, 32'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual hang expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic e, v; int seed;
        seed = $urandom(32'h5eed);
        m_en = 0; m_rst = 0; m_hr = 0; m_sel = '0; m_line = '0; m_halted = '0;
        for (int i = 0; i < DC; i++) m_data[i] = '0;
        for (int i = 0; i < PS; i++) m_pbuf[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
        chk("R1 fetch_rsp_valid idle", {31'd0, fetch_rsp_valid}, 32'd0);
        chk("R1 halt_req", 32'(halt_req), 32'd0);
        ctrl_read("R1 ctrl reset value");
        @(negedge clk);
        chk("R11 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);

        // R7 capability words
        dmi(1'b0, 7'h16, '0, rd, e, v);
        chk("R7 datacount", rd, 32'(DC)); chk("R7 no err", {31'd0, e}, 0);
        dmi(1'b0, 7'h17, '0, rd, e, v);
        chk("R7 progsize", rd, 32'(PS));

        // R2/R3 window edges
        dmi(1'b1, 7'h04 + 7'(DC - 1), 32'hDEAD_BEEF, rd, e, v);
        m_data[DC-1] = 32'hDEAD_BEEF;
        chk("R11 write rdata zero", rd, 0);
        dmi(1'b0, 7'h04 + 7'(DC - 1), '0, rd, e, v);
        chk("R2 last data word", rd, 32'hDEAD_BEEF);
        dmi(1'b1, 7'h20, 32'h1234_5678, rd, e, v);
        m_pbuf[0] = 32'h1234_5678;
        dmi(1'b0, 7'h20, '0, rd, e, v);
        chk("R3 first pbuf word", rd, 32'h1234_5678);

        // R8 unmapped and refused writes leave state unchanged
        dmi(1'b1, 7'h16, 32'hFFFF_FFFF, rd, e, v);
        chk("R8 cmd status write err", {31'd0, e}, 1); chk("R8 rdata zero", rd, 0);
        dmi(1'b1, 7'h04 + 7'(DC), 32'hAAAA_5555, rd, e, v);
        chk("R8 beyond data window err", {31'd0, e}, 1);
        dmi(1'b1, 7'h20 + 7'(PS), 32'hAAAA_5555, rd, e, v);
        chk("R8 beyond pbuf window err", {31'd0, e}, 1);
        dmi(1'b0, 7'h7F, '0, rd, e, v);
        chk("R8 unmapped read err", {31'd0, e}, 1); chk("R8 unmapped rdata", rd, 0);
        dmi(1'b0, 7'h04 + 7'(DC - 1), '0, rd, e, v);
        chk("R8 data word untouched", rd, 32'hDEAD_BEEF);
        ctrl_read("R8 ctrl untouched");

        // R4 gating: enable 0 ignores other fields
        ctrl_write(32'h8002_0002);
        ctrl_read("R4 fields gated by enable");
        ctrl_write(32'h8001_0003);
        ctrl_read("R4 R5 halt hart1");
        ctrl_write(32'h8005_0001);
        ctrl_read("R6 absent hart status");
        ctrl_write(32'h0000_0000);
        ctrl_read("R4 deactivate clears");

        // R9/R10 fetch port
        fetch(1'b1, 10'd2, rd, e, v);
        chk("R10 store err", {30'd0, v, e}, 32'h3); chk("R10 store rdata", rd, 0);
        ctrl_write(32'h0002_0001);
        ctrl_read("R10 store sets no halted");
        fetch(1'b0, 10'd2, rd, e, v);
        chk("R9 jump-to-self", rd, 32'h0000_006F);
        chk("R9 load ok", {30'd0, v, e}, 32'h2);
        ctrl_read("R6 R9 hart2 halted");
        fetch(1'b0, 10'd1023, rd, e, v);
        chk("R9 top slot", rd, 32'h0000_006F);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 6;
            case (op)
                0: begin
                    int i = $urandom % DC; logic [31:0] d = $urandom;
                    dmi(1'b1, 7'h04 + 7'(i), d, rd, e, v); m_data[i] = d;
                    chk("R2 data write no err", {31'd0, e}, 0);
                end
                1: begin
                    int i = $urandom % DC;
                    dmi(1'b0, 7'h04 + 7'(i), '0, rd, e, v);
                    chk("R2 data readback", rd, m_data[i]);
                end
                2: begin
                    int i = $urandom % PS; logic [31:0] d = $urandom;
                    dmi(1'b1, 7'h20 + 7'(i), d, rd, e, v); m_pbuf[i] = d;
                    dmi(1'b0, 7'h20 + 7'(($urandom % PS)), '0, rd, e, v);
                    chk("R3 pbuf readback", rd, m_pbuf[req_addr - 7'h20]);
                end
                3: begin
                    logic [31:0] w = $urandom;
                    w[25:16] = 10'($urandom % 6);
                    w[0] = ($urandom % 4) != 0;
                    ctrl_write(w);
                end
                4: ctrl_read("R6 ctrl status random");
                default: begin
                    logic wr = ($urandom % 4) == 0;
                    logic [9:0] s = 10'($urandom % 8);
                    fetch(wr, s, rd, e, v);
                    chk(wr ? "R10 store err" : "R9 load word", rd, wr ? 0 : 32'h6F);
                end
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule